// File: doc/BRIEF.md
# UART Receive Character Queue with Per-Frame Error Status

This block sits on the receive side of a UART, after the bit sampler and shift register and before the host's data and status locations. When the front end finishes a frame it raises a one-cycle strobe with the character and that frame's stop-bit and parity results. The frame first lands in a single holding stage that stands for the shift register. From there it moves into a small FIFO, two entries deep by default, as soon as an entry is free. Each FIFO entry carries its character, its own frame-error bit, its own parity-error bit and its own overrun bit. The status outputs therefore always describe the character currently shown on the data output. The host must sample status before it reads data, because a data read moves the queue forward.

A frame is lost only under one condition. Both FIFO entries must be occupied, the holding stage must still contain a finished frame, and the front end must report a new start bit. When that happens the held frame is dropped. The loss is recorded on the next frame that does make it into the FIFO, and that frame's arrival clears the pending loss. Dropping the receiver enable empties the FIFO, the holding stage and any pending loss.

Top module: `uart_rxbuf`

## Requirements
- R1: Characters leave in arrival order. A frame strobed at clock edge k, with space in the FIFO, is visible on the outputs and raises `rx_avail` after edge k+1. Each `rd_data` pulse at an edge, while data is present, removes the head entry at that edge.
- R2: `st_frame_err` and `st_par_err` always show the bits captured with the frame now on `rd_dout`. They change only when the head entry changes.
- R3: A frame is lost only when `start_seen` is high at an edge while the FIFO is full, the holding stage is occupied and no read happens at that edge. A start bit in any other state loses nothing.
- R4: After a loss, the next frame that enters the FIFO carries `st_overrun` = 1. The frame that was held is discarded. Frames entering after that one carry `st_overrun` = 0.
- R5: A frame strobed while `par_check_en` = 0 stores a parity-error bit of 0, whatever `frame_par_err` was.
- R6: `rx_avail` is 1 exactly while unread characters are queued. When `rx_en` = 0 at an edge, the FIFO, the holding stage and the pending loss are all cleared, and strobes at that edge are ignored.
- R7: `char_len` selects the character width: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Bits above the selected width are stored and read as 0.
- R8: A `st_wr` pulse with any `st_wdata` value leaves all three status outputs unchanged.
- R9: A frame waiting in the holding stage while the FIFO is full moves into the FIFO at the same edge as the read that frees an entry. It does so without overrun when no start bit was reported.
- R10: With the FIFO empty, `rd_dout` and all status outputs read 0, and an `rd_data` pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low flushes all stored state |
| char_len | input | 2 | Character width select (0..3 = 5..8 bits) |
| par_check_en | input | 1 | Parity checking enabled for the frame being strobed |
| frame_done | input | 1 | One-cycle strobe: a frame has finished |
| frame_char | input | 8 | Received character bits, LSB aligned |
| frame_stop_err | input | 1 | First stop bit was sampled low |
| frame_par_err | input | 1 | Parity mismatch reported by the front end |
| start_seen | input | 1 | One-cycle pulse: a new start bit was detected |
| rd_data | input | 1 | Host read of the data location; pops the head |
| st_wr | input | 1 | Host write to the status location |
| st_wdata | input | 3 | Data of that write (no effect) |
| rd_dout | output | 8 | Head character |
| st_frame_err | output | 1 | Frame error of the head character |
| st_par_err | output | 1 | Parity error of the head character |
| st_overrun | output | 1 | At least one frame was lost before the head character |
| rx_avail | output | 1 | Unread data present |

## Verification
A frame strobed at edge k sits in the holding stage after edge k. Given space, it reaches the outputs only after edge k+1. The bench drives every input at a falling edge and samples at later falling edges, so it can check both that nothing is visible after the first edge and that the character and its flags are visible after the second. A read, a flush, a start bit or a status write takes effect at the rising edge that samples it. Its result is checked at the next falling edge, and the following read shows whether a held frame slid in at that same edge or was dropped.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;
   parameter int unsigned RXB_MAX_CHAR = 8;

   typedef struct packed {
      logic [RXB_MAX_CHAR-1:0] chr;
      logic                    ferr;
      logic                    perr;
      logic                    ovr;
   } rxb_entry_t;

   // keep bits below min_w + len, clear the rest
   function automatic logic [RXB_MAX_CHAR-1:0] rxb_width_mask(input logic [1:0] len,
                                                              input int unsigned min_w);
      logic [RXB_MAX_CHAR-1:0] m;
      for (int i = 0; i < RXB_MAX_CHAR; i++)
         m[i] = (i < (min_w + int'(len)));
      return m;
   endfunction
endpackage

// File: rtl/rxbuf_stage.sv
module rxbuf_stage
   import uart_rxbuf_pkg::*;
#(
   parameter int unsigned MIN_CHAR_W = 5
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rx_en,
   input  logic [1:0]              char_len,
   input  logic                    par_check_en,
   input  logic                    frame_done,
   input  logic [RXB_MAX_CHAR-1:0] frame_char,
   input  logic                    frame_stop_err,
   input  logic                    frame_par_err,
   input  logic                    start_seen,
   input  logic                    fifo_full,
   input  logic                    fifo_pop,
   output logic                    push,
   output rxb_entry_t              push_entry
);
   logic                    hold_vld;
   logic [RXB_MAX_CHAR-1:0] hold_chr;
   logic                    hold_ferr;
   logic                    hold_perr;
   logic                    ovr_pend;
   logic                    space;
   logic                    lose;

   assign space = !fifo_full || fifo_pop;
   assign push  = rx_en && hold_vld && space;
   assign lose  = rx_en && start_seen && hold_vld && !space && !frame_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_vld  <= 1'b0;
         hold_chr  <= '0;
         hold_ferr <= 1'b0;
         hold_perr <= 1'b0;
         ovr_pend  <= 1'b0;
      end else if (!rx_en) begin
         hold_vld <= 1'b0;
         ovr_pend <= 1'b0;
      end else begin
         if (frame_done) begin
            hold_vld  <= 1'b1;
            hold_chr  <= frame_char & rxb_width_mask(char_len, MIN_CHAR_W);
            hold_ferr <= frame_stop_err;
            hold_perr <= frame_par_err && par_check_en;
         end else if (push || lose) begin
            hold_vld <= 1'b0;
         end
         if (lose)
            ovr_pend <= 1'b1;
         else if (push)
            ovr_pend <= 1'b0;
      end
   end

   assign push_entry = '{chr: hold_chr, ferr: hold_ferr, perr: hold_perr, ovr: ovr_pend};

   AST_PAR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && frame_done && !par_check_en) |=> !hold_perr); // R5
   AST_NARROW_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && frame_done && char_len == 2'd0) |=> (hold_chr[RXB_MAX_CHAR-1:MIN_CHAR_W] == '0)); // R7
   AST_LOSS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && start_seen && hold_vld && fifo_full && !fifo_pop && !frame_done) |=> (ovr_pend && !hold_vld)); // R3
   AST_LOSS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !lose) |=> !ovr_pend); // R4
endmodule

// File: rtl/rxbuf_fifo.sv
module rxbuf_fifo
   import uart_rxbuf_pkg::*;
#(
   parameter int unsigned DEPTH = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flush,
   input  logic       push,
   input  rxb_entry_t push_entry,
   input  logic       pop,
   output logic       full,
   output logic       nonempty,
   output rxb_entry_t head
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   rxb_entry_t       slot_q [DEPTH];

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxbuf_fifo: DEPTH must be at least 2");
      end
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         rxb_entry_t ent;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ent <= '0;
            else if (push && !flush && wr_ptr == PTR_W'(g))
               ent <= push_entry;
         end
         assign slot_q[g] = ent;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push)
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (pop)
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign full     = (count == FULL_CNT);
   assign nonempty = (count != '0);
   assign head     = nonempty ? slot_q[rd_ptr] : '0;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !flush) |-> !full); // R1
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> nonempty); // R10
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !nonempty); // R6
endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf
   import uart_rxbuf_pkg::*;
#(
   parameter int unsigned DEPTH      = 2,
   parameter int unsigned MIN_CHAR_W = 5
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rx_en,
   input  logic [1:0]              char_len,
   input  logic                    par_check_en,
   input  logic                    frame_done,
   input  logic [RXB_MAX_CHAR-1:0] frame_char,
   input  logic                    frame_stop_err,
   input  logic                    frame_par_err,
   input  logic                    start_seen,
   input  logic                    rd_data,
   input  logic                    st_wr,
   input  logic [2:0]              st_wdata,
   output logic [RXB_MAX_CHAR-1:0] rd_dout,
   output logic                    st_frame_err,
   output logic                    st_par_err,
   output logic                    st_overrun,
   output logic                    rx_avail
);
   generate
      if (MIN_CHAR_W + 3 != RXB_MAX_CHAR) begin : g_bad_width
         $error("uart_rxbuf: MIN_CHAR_W + 3 must equal the stored character width");
      end
   endgenerate

   logic       push, pop, full, nonempty;
   rxb_entry_t push_entry, head;

   assign pop = rx_en && rd_data && nonempty;

   rxbuf_stage #(.MIN_CHAR_W(MIN_CHAR_W)) u_stage (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_en         (rx_en),
      .char_len      (char_len),
      .par_check_en  (par_check_en),
      .frame_done    (frame_done),
      .frame_char    (frame_char),
      .frame_stop_err(frame_stop_err),
      .frame_par_err (frame_par_err),
      .start_seen    (start_seen),
      .fifo_full     (full),
      .fifo_pop      (pop),
      .push          (push),
      .push_entry    (push_entry)
   );

   rxbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (!rx_en),
      .push      (push),
      .push_entry(push_entry),
      .pop       (pop),
      .full      (full),
      .nonempty  (nonempty),
      .head      (head)
   );

   assign rd_dout      = head.chr;
   assign st_frame_err = head.ferr;
   assign st_par_err   = head.perr;
   assign st_overrun   = head.ovr;
   assign rx_avail     = nonempty;

   AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && st_wdata != 3'b000 && rx_en && rx_avail && !rd_data)
      |=> $stable({st_frame_err, st_par_err, st_overrun, rd_dout})); // R8
   AST_FLUSH_CLEARS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_avail); // R6
   AST_AVAIL_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_avail) |-> $past(push)); // R1
   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_avail |-> (rd_dout == '0 && !st_frame_err && !st_par_err && !st_overrun)); // R10
endmodule

// File: tb/tb_uart_rxbuf.sv
module tb_uart_rxbuf;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0;
   logic [1:0] char_len = 2'd3;
   logic       par_check_en = 1'b1;
   logic       frame_done = 1'b0;
   logic [7:0] frame_char = '0;
   logic       frame_stop_err = 1'b0;
   logic       frame_par_err = 1'b0;
   logic       start_seen = 1'b0;
   logic       rd_data = 1'b0;
   logic       st_wr = 1'b0;
   logic [2:0] st_wdata = '0;
   logic [7:0] rd_dout;
   logic       st_frame_err, st_par_err, st_overrun, rx_avail;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   uart_rxbuf dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .char_len(char_len),
      .par_check_en(par_check_en), .frame_done(frame_done), .frame_char(frame_char),
      .frame_stop_err(frame_stop_err), .frame_par_err(frame_par_err),
      .start_seen(start_seen), .rd_data(rd_data), .st_wr(st_wr), .st_wdata(st_wdata),
      .rd_dout(rd_dout), .st_frame_err(st_frame_err), .st_par_err(st_par_err),
      .st_overrun(st_overrun), .rx_avail(rx_avail)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // head view: {avail, ovr, perr, ferr, char}
   task automatic chk_head(input string req, input logic av, input logic [7:0] c,
                           input logic fe, input logic pe, input logic ov);
      chk(req, {rx_avail, st_overrun, st_par_err, st_frame_err, rd_dout},
               {av, ov, pe, fe, c});
   endtask

   task automatic strobe(input logic [7:0] c, input logic fe, input logic pe);
      frame_done = 1'b1; frame_char = c; frame_stop_err = fe; frame_par_err = pe;
      tick();
      frame_done = 1'b0; frame_stop_err = 1'b0; frame_par_err = 1'b0;
   endtask

   task automatic rd();
      rd_data = 1'b1;
      tick();
      rd_data = 1'b0;
   endtask

   task automatic start_pulse();
      start_seen = 1'b1;
      tick();
      start_seen = 1'b0;
   endtask

   task automatic t_reset();
      chk_head("R10 reset empty", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_latency_order();
      strobe(8'hA5, 1'b0, 1'b0);
      chk("R1 not visible after first edge", rx_avail, 0);
      tick();
      chk_head("R1 visible after second edge", 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
      strobe(8'h3C, 1'b0, 1'b0);
      tick();
      chk_head("R1 head stays first", 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0);
      rd();
      chk_head("R1 second after read", 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0);
      rd();
      chk_head("R6 empty after reads", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
      rd();
      chk_head("R10 empty read no effect", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_flags_travel();
      strobe(8'h11, 1'b1, 1'b0);
      strobe(8'h22, 1'b0, 1'b1);
      tick();
      chk_head("R2 first frame flags", 1'b1, 8'h11, 1'b1, 1'b0, 1'b0);
      rd();
      chk_head("R2 second frame flags", 1'b1, 8'h22, 1'b0, 1'b1, 1'b0);
      rd();
      par_check_en = 1'b0;
      strobe(8'h33, 1'b0, 1'b1);
      par_check_en = 1'b1;
      tick();
      chk_head("R5 parity off stores zero", 1'b1, 8'h33, 1'b0, 1'b0, 1'b0);
      rd();
   endtask

   task automatic t_width();
      for (int l = 0; l < 4; l++) begin
         logic [7:0] exp;
         char_len = 2'(l);
         strobe(8'hFF, 1'b0, 1'b0);
         tick();
         exp = 8'hFF >> (3 - l);
         chk_head($sformatf("R7 width select %0d", l), 1'b1, exp, 1'b0, 1'b0, 1'b0);
         rd();
      end
      char_len = 2'd3;
   endtask

   task automatic t_status_write();
      strobe(8'h44, 1'b0, 1'b0);
      strobe(8'h55, 1'b1, 1'b0);
      tick();
      st_wr = 1'b1; st_wdata = 3'b111;
      tick();
      st_wr = 1'b0;
      chk_head("R8 write ones ignored", 1'b1, 8'h44, 1'b0, 1'b0, 1'b0);
      rd();
      st_wr = 1'b1; st_wdata = 3'b000;
      tick();
      st_wr = 1'b0;
      chk_head("R8 write zeros ignored", 1'b1, 8'h55, 1'b1, 1'b0, 1'b0);
      rd();
   endtask

   task automatic t_slide_in();
      strobe(8'h61, 1'b0, 1'b0);
      strobe(8'h62, 1'b0, 1'b0);
      strobe(8'h63, 1'b0, 1'b0);
      tick();
      chk_head("R9 full head", 1'b1, 8'h61, 1'b0, 1'b0, 1'b0);
      rd();
      rd();
      chk_head("R9 held frame entered", 1'b1, 8'h63, 1'b0, 1'b0, 1'b0);
      rd();
      chk("R9 drained", rx_avail, 0);
   endtask

   task automatic t_start_no_loss();
      strobe(8'h71, 1'b0, 1'b0);
      strobe(8'h72, 1'b0, 1'b0);
      tick();
      start_pulse();
      strobe(8'h73, 1'b0, 1'b0);
      rd();
      chk_head("R3 start with empty stage no loss", 1'b1, 8'h72, 1'b0, 1'b0, 1'b0);
      rd();
      chk_head("R3 third frame kept", 1'b1, 8'h73, 1'b0, 1'b0, 1'b0);
      rd();
   endtask

   task automatic t_overrun();
      strobe(8'h81, 1'b0, 1'b0);
      strobe(8'h82, 1'b0, 1'b0);
      strobe(8'h83, 1'b0, 1'b0);
      tick();
      start_pulse();
      chk_head("R3 head unchanged at loss", 1'b1, 8'h81, 1'b0, 1'b0, 1'b0);
      rd();
      chk_head("R4 older frame no overrun", 1'b1, 8'h82, 1'b0, 1'b0, 1'b0);
      rd();
      chk_head("R4 held frame discarded", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
      strobe(8'h84, 1'b0, 1'b0);
      tick();
      chk_head("R4 next frame carries overrun", 1'b1, 8'h84, 1'b0, 1'b0, 1'b1);
      rd();
      strobe(8'h85, 1'b0, 1'b0);
      tick();
      chk_head("R4 overrun cleared after", 1'b1, 8'h85, 1'b0, 1'b0, 1'b0);
      rd();
   endtask

   task automatic t_flush();
      strobe(8'h91, 1'b0, 1'b0);
      strobe(8'h92, 1'b0, 1'b0);
      strobe(8'h93, 1'b0, 1'b0);
      start_pulse();
      chk("R6 full before flush", rx_avail, 1);
      rx_en = 1'b0;
      tick();
      rx_en = 1'b1;
      chk_head("R6 flush empties", 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
      tick();
      chk("R6 held frame flushed", rx_avail, 0);
      strobe(8'h94, 1'b0, 1'b0);
      tick();
      chk_head("R6 pending loss flushed", 1'b1, 8'h94, 1'b0, 1'b0, 1'b0);
      rd();
   endtask

   initial begin
      #(200_000 * 20);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      rx_en = 1'b1;
      tick();
      t_latency_order();
      t_flags_travel();
      t_width();
      t_status_write();
      t_slide_in();
      t_start_no_loss();
      t_overrun();
      t_flush();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule